// File: doc/BRIEF.md
# CAN Operating-Mode Sequencer and Interrupt Flags

This block sequences the operating modes of a CAN controller: reset, normal transmit/receive, halt and sleep. Software requests modes through a three-bit control register. An asynchronous active-low hardware reset also puts the block into reset mode. The block reports two status bits, one for reset and one for halt, and a 3-bit mode code.

It keeps two interrupt flags, each with its own mask bit:

- The mode-transition flag records completed moves into reset, halt or sleep.
- The receive flag records a frame stored into a mailbox whose per-mailbox interrupt mask is clear.

A registered interrupt output combines the unmasked flags. The return from halt or sleep to normal operation is timed by a bit-timing pulse input. This pulse arrives once per bit time, at the TSEG2 sample point. The halt-status bit therefore clears between one and two bit times after the request is withdrawn.

The bit stream, arbitration, message storage and the bit-timing generator sit outside this block.

Top module: `can_mode_ctl`

## Requirements
- R1: After hardware reset the block is in reset mode. In that state:
  - mode_o is 0, stat_reset_o is 1 and stat_halt_o is 0.
  - flag_mode_o is 1, and both mask bits are 1.
  - flag_rx_o and irq_o are 0.
  - The control register holds 3'b001, so the block stays in reset until software clears bit 0.
- R2: Mode codes and the reset bit:
  - Mode codes are 0 reset, 1 normal, 2 halt-pending, 3 halt, 4 sleep and 5 exit-pending.
  - Control register bit 0 requests reset. It overrides every other bit.
  - The cycle after the register holds bit 0 set, stat_reset_o is 1. If stat_reset_o rose, flag_mode_o is set and mask_mode_o is forced to 1 in that same cycle.
  - Clearing bit 0 returns the block to normal mode one cycle later.
- R3: Control bit 1 requests halt. From normal mode the block moves to halt-pending. On the next bit_tick it enters halt, raising stat_halt_o and setting flag_mode_o in the same cycle.
- R4: Control bit 2 requests sleep, and sleep is entered only from halt mode.
  - In normal mode the sleep bit changes neither the mode nor the status bits nor flag_mode_o.
  - In halt mode, one cycle after the bit is set, the mode is sleep, flag_mode_o is set and stat_halt_o stays 1.
- R5: Clearing the sleep bit while the halt bit stays set moves the block from sleep directly to halt without setting flag_mode_o.
- R6: Leaving halt or sleep with bits 1 and 2 both clear enters exit-pending, with stat_halt_o still 1. The block then returns to normal on the second bit_tick, and stat_halt_o becomes 0 in the cycle after that second tick.
- R7: A halt request made again during exit-pending returns the block to halt without stat_halt_o ever clearing, and flag_mode_o is not set.
- R8: Clearing the mode-transition flag:
  - A write on clr_wr with clr_mode = 1 clears flag_mode_o.
  - With clr_mode = 0 the write has no effect.
  - If a set condition occurs in the same cycle as the clear, the flag ends up set.
- R9: Receive flag:
  - flag_rx_o is set when rx_store names a mailbox whose mb_int_mask bit is 0. A store to a masked mailbox leaves it unchanged.
  - It clears when every bit of rx_pend is 0.
  - A set in the same cycle as the clear leaves it set.
- R10: irq_o equals the OR over both flags of (flag AND NOT mask), taken one cycle later. The mask write maps msk_wdata bit 0 to the mode mask and bit 1 to the receive mask.
- R11: A reset request from halt or sleep enters reset mode in one cycle. stat_halt_o clears and stat_reset_o sets in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control value: bit 0 reset, bit 1 halt, bit 2 sleep request |
| clr_wr | input | 1 | Flag clear write strobe |
| clr_mode | input | 1 | Write-1 clear of the mode-transition flag |
| msk_wr | input | 1 | Mask register write strobe |
| msk_wdata | input | 2 | Mask value: bit 0 mode flag, bit 1 receive flag |
| bit_tick | input | 1 | One-cycle pulse per bit time at the TSEG2 sample point |
| rx_store | input | 1 | A data frame was stored this cycle |
| rx_store_mb | input | MB_W | Mailbox index of the stored frame |
| mb_int_mask | input | NUM_MB | Per-mailbox receive interrupt mask |
| rx_pend | input | NUM_MB | Per-mailbox receive-pending vector |
| mode_o | output | 3 | Current mode code |
| stat_reset_o | output | 1 | Reset-status bit |
| stat_halt_o | output | 1 | Halt-status bit (also set during sleep and exit-pending) |
| flag_mode_o | output | 1 | Mode-transition interrupt flag |
| flag_rx_o | output | 1 | Receive interrupt flag |
| mask_mode_o | output | 1 | Mode-transition flag mask |
| mask_rx_o | output | 1 | Receive flag mask |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a flag's set condition and its clear: a software write-1 clear of the mode flag against a completed move into halt, and an all-zero pending vector against a store to an unmasked mailbox. The bench provokes each pair by driving both causes before the same clock edge: bit_tick with clr_wr in halt-pending, and rx_store with rx_pend all zero. It passes only if the flag reads 1 afterwards. The second pair is a reset request against a forced mask: it is judged by entering reset from sleep with the mode mask cleared, and then seeing the mask at 1 and irq_o staying low.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [2:0] {
    MODE_RESET     = 3'd0,
    MODE_NORMAL    = 3'd1,
    MODE_HALT_PEND = 3'd2,
    MODE_HALT      = 3'd3,
    MODE_SLEEP     = 3'd4,
    MODE_EXIT_PEND = 3'd5
  } mode_e;

  // control register layout
  localparam int CTL_W     = 3;
  localparam int CTL_RST   = 0;
  localparam int CTL_HALT  = 1;
  localparam int CTL_SLEEP = 2;

  // flag / mask layout
  localparam int NUM_FLG  = 2;
  localparam int FLG_MODE = 0;
  localparam int FLG_RX   = 1;

endpackage

// File: rtl/can_rst_sync.sv
module can_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
#(
  parameter int EXIT_EXTRA_BITS = 1,
  localparam int CNT_W = $clog2(EXIT_EXTRA_BITS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctl_q,
  input  logic             bit_tick,
  output mode_e            mode_o,
  output logic             stat_reset_o,
  output logic             stat_halt_o,
  output logic             set_mode_o,
  output logic             reset_entry_o
);

  localparam logic [CNT_W-1:0] EXIT_LAST = CNT_W'(EXIT_EXTRA_BITS);

  mode_e            state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             stat_reset_d, stat_halt_d;

  logic req_rst, req_halt, req_sleep;
  assign req_rst   = ctl_q[CTL_RST];
  assign req_halt  = ctl_q[CTL_HALT];
  assign req_sleep = ctl_q[CTL_SLEEP];

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (req_rst) begin
      state_d = MODE_RESET;
    end else begin
      unique case (state_q)
        MODE_RESET:     state_d = MODE_NORMAL;
        MODE_NORMAL:    if (req_halt) state_d = MODE_HALT_PEND;
        MODE_HALT_PEND: begin
          if (!req_halt)     state_d = MODE_NORMAL;
          else if (bit_tick) state_d = MODE_HALT;
        end
        MODE_HALT: begin
          if (req_sleep) begin
            state_d = MODE_SLEEP;
          end else if (!req_halt) begin
            state_d = MODE_EXIT_PEND;
            cnt_d   = '0;
            cnt_en  = 1'b1;
          end
        end
        MODE_SLEEP: begin
          if (!req_sleep) begin
            if (req_halt) begin
              state_d = MODE_HALT;
            end else begin
              state_d = MODE_EXIT_PEND;
              cnt_d   = '0;
              cnt_en  = 1'b1;
            end
          end
        end
        MODE_EXIT_PEND: begin
          if (req_halt) begin
            state_d = MODE_HALT;
          end else if (bit_tick) begin
            if (cnt_q == EXIT_LAST) begin
              state_d = MODE_NORMAL;
            end else begin
              cnt_d  = cnt_q + 1'b1;
              cnt_en = 1'b1;
            end
          end
        end
        default:        state_d = MODE_RESET;
      endcase
    end
  end

  always_comb begin
    stat_reset_d = (state_d == MODE_RESET);
    stat_halt_d  = (state_d == MODE_HALT) || (state_d == MODE_SLEEP) ||
                   (state_d == MODE_EXIT_PEND);
  end

  // flag events: rising status bits or halt-to-sleep
  assign reset_entry_o = stat_reset_d & ~stat_reset_q_w;
  assign set_mode_o    = reset_entry_o | (stat_halt_d & ~stat_halt_q_w) |
                         ((state_q == MODE_HALT) && (state_d == MODE_SLEEP));

  logic stat_reset_q_w, stat_halt_q_w;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= MODE_RESET;
      stat_reset_q_w <= 1'b1;
      stat_halt_q_w  <= 1'b0;
    end else begin
      state_q        <= state_d;
      stat_reset_q_w <= stat_reset_d;
      stat_halt_q_w  <= stat_halt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign mode_o       = state_q;
  assign stat_reset_o = stat_reset_q_w;
  assign stat_halt_o  = stat_halt_q_w;

endmodule

// File: rtl/can_rx_detect.sv
module can_rx_detect #(
  parameter int NUM_MB = 16,
  localparam int MB_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic              rx_store,
  input  logic [MB_W-1:0]   rx_store_mb,
  input  logic [NUM_MB-1:0] mb_int_mask,
  input  logic [NUM_MB-1:0] rx_pend,
  output logic              rx_set_o,
  output logic              rx_clr_o
);

  logic [NUM_MB-1:0] hit;

  // decode the stored mailbox against its interrupt mask
  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    assign hit[g] = rx_store && (rx_store_mb == MB_W'(g)) && !mb_int_mask[g];
  end

  assign rx_set_o = |hit;
  assign rx_clr_o = ~|rx_pend;

endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
  import can_mode_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_mode,
  input  logic               reset_entry,
  input  logic               clr_wr,
  input  logic               clr_mode,
  input  logic               msk_wr,
  input  logic [NUM_FLG-1:0] msk_wdata,
  input  logic               rx_set,
  input  logic               rx_clr,
  output logic [NUM_FLG-1:0] flag_o,
  output logic [NUM_FLG-1:0] mask_o,
  output logic               irq_o
);

  localparam logic [NUM_FLG-1:0] FLAG_RST = NUM_FLG'(1) << FLG_MODE;

  logic [NUM_FLG-1:0] set_vec, clr_vec;
  logic [NUM_FLG-1:0] flag_q, flag_d;
  logic [NUM_FLG-1:0] mask_q, mask_d;
  logic               mask_en;
  logic               irq_d, irq_q;

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    set_vec[FLG_MODE] = set_mode;
    clr_vec[FLG_MODE] = clr_wr & clr_mode;
    set_vec[FLG_RX]   = rx_set;
    clr_vec[FLG_RX]   = rx_clr;
  end

  // per-flag update: a set beats a clear
  for (genvar g = 0; g < NUM_FLG; g++) begin : g_flag
    always_comb begin
      if (set_vec[g])      flag_d[g] = 1'b1;
      else if (clr_vec[g]) flag_d[g] = 1'b0;
      else                 flag_d[g] = flag_q[g];
    end
  end

  always_comb begin
    mask_en = msk_wr | reset_entry;
    mask_d  = msk_wr ? msk_wdata : mask_q;
    if (reset_entry) mask_d[FLG_MODE] = 1'b1;
    irq_d = |(flag_q & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= FLAG_RST;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/can_mode_ctl.sv
module can_mode_ctl
  import can_mode_pkg::*;
#(
  parameter int NUM_MB          = 16,
  parameter int EXIT_EXTRA_BITS = 1,
  parameter int RST_STAGES      = 2,
  localparam int MB_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [2:0]        ctl_wdata,
  input  logic              clr_wr,
  input  logic              clr_mode,
  input  logic              msk_wr,
  input  logic [1:0]        msk_wdata,
  input  logic              bit_tick,
  input  logic              rx_store,
  input  logic [MB_W-1:0]   rx_store_mb,
  input  logic [NUM_MB-1:0] mb_int_mask,
  input  logic [NUM_MB-1:0] rx_pend,
  output logic [2:0]        mode_o,
  output logic              stat_reset_o,
  output logic              stat_halt_o,
  output logic              flag_mode_o,
  output logic              flag_rx_o,
  output logic              mask_mode_o,
  output logic              mask_rx_o,
  output logic              irq_o
);

  logic               rst_sync_n;
  logic [CTL_W-1:0]   ctl_q;
  mode_e              mode_w;
  logic               set_mode, reset_entry;
  logic               rx_set, rx_clr;
  logic [NUM_FLG-1:0] flag_w, mask_w;

  can_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // control register: holds the reset request after hardware reset
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctl_q <= CTL_W'(1) << CTL_RST;
    else if (ctl_wr)  ctl_q <= ctl_wdata;
  end

  can_mode_fsm #(.EXIT_EXTRA_BITS(EXIT_EXTRA_BITS)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .ctl_q         (ctl_q),
    .bit_tick      (bit_tick),
    .mode_o        (mode_w),
    .stat_reset_o  (stat_reset_o),
    .stat_halt_o   (stat_halt_o),
    .set_mode_o    (set_mode),
    .reset_entry_o (reset_entry)
  );

  can_rx_detect #(.NUM_MB(NUM_MB)) u_rx (
    .rx_store    (rx_store),
    .rx_store_mb (rx_store_mb),
    .mb_int_mask (mb_int_mask),
    .rx_pend     (rx_pend),
    .rx_set_o    (rx_set),
    .rx_clr_o    (rx_clr)
  );

  can_irq_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .set_mode    (set_mode),
    .reset_entry (reset_entry),
    .clr_wr      (clr_wr),
    .clr_mode    (clr_mode),
    .msk_wr      (msk_wr),
    .msk_wdata   (msk_wdata),
    .rx_set      (rx_set),
    .rx_clr      (rx_clr),
    .flag_o      (flag_w),
    .mask_o      (mask_w),
    .irq_o       (irq_o)
  );

  assign mode_o      = mode_w;
  assign flag_mode_o = flag_w[FLG_MODE];
  assign flag_rx_o   = flag_w[FLG_RX];
  assign mask_mode_o = mask_w[FLG_MODE];
  assign mask_rx_o   = mask_w[FLG_RX];

endmodule

// File: rtl/can_mode_ctl_chk.sv
module can_mode_ctl_chk #(
  parameter int NUM_MB = 16,
  parameter int MB_W   = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode_o,
  input logic              stat_reset_o,
  input logic              stat_halt_o,
  input logic              flag_mode_o,
  input logic              flag_rx_o,
  input logic              mask_mode_o,
  input logic              mask_rx_o,
  input logic              irq_o,
  input logic              clr_wr,
  input logic              clr_mode,
  input logic              rx_store,
  input logic [MB_W-1:0]   rx_store_mb,
  input logic [NUM_MB-1:0] mb_int_mask
);

  // R2
  reset_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_reset_o) |-> (flag_mode_o && mask_mode_o));

  // R4
  sleep_from_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4 && $past(mode_o) != 3'd4) |-> ($past(mode_o) == 3'd3));

  // R6
  halt_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_halt_o) |-> (mode_o == 3'd1 || mode_o == 3'd0));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_mode_o && !(clr_wr && clr_mode)) |=> flag_mode_o);

  // R9
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_store && !mb_int_mask[rx_store_mb]) |=> flag_rx_o);

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|({flag_rx_o, flag_mode_o} & ~{mask_rx_o, mask_mode_o})) |=> irq_o);

  // R10
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|({flag_rx_o, flag_mode_o} & ~{mask_rx_o, mask_mode_o})) |=> !irq_o);

endmodule

bind can_mode_ctl can_mode_ctl_chk #(.NUM_MB(NUM_MB)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_o       (mode_o),
  .stat_reset_o (stat_reset_o),
  .stat_halt_o  (stat_halt_o),
  .flag_mode_o  (flag_mode_o),
  .flag_rx_o    (flag_rx_o),
  .mask_mode_o  (mask_mode_o),
  .mask_rx_o    (mask_rx_o),
  .irq_o        (irq_o),
  .clr_wr       (clr_wr),
  .clr_mode     (clr_mode),
  .rx_store     (rx_store),
  .rx_store_mb  (rx_store_mb),
  .mb_int_mask  (mb_int_mask)
);

// File: tb/can_mode_ctl_tb_top.sv
`timescale 1ns/1ps
module can_mode_ctl_tb_top;

  localparam int NUM_MB = 16;
  localparam int MB_W   = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ctl_wr;
  logic [2:0]        ctl_wdata;
  logic              clr_wr, clr_mode;
  logic              msk_wr;
  logic [1:0]        msk_wdata;
  logic              bit_tick;
  logic              rx_store;
  logic [MB_W-1:0]   rx_store_mb;
  logic [NUM_MB-1:0] mb_int_mask;
  logic [NUM_MB-1:0] rx_pend;
  logic [2:0]        mode_o;
  logic              stat_reset_o, stat_halt_o;
  logic              flag_mode_o, flag_rx_o;
  logic              mask_mode_o, mask_rx_o;
  logic              irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  can_mode_ctl #(.NUM_MB(NUM_MB)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .clr_wr(clr_wr), .clr_mode(clr_mode), .msk_wr(msk_wr), .msk_wdata(msk_wdata),
    .bit_tick(bit_tick), .rx_store(rx_store), .rx_store_mb(rx_store_mb),
    .mb_int_mask(mb_int_mask), .rx_pend(rx_pend), .mode_o(mode_o),
    .stat_reset_o(stat_reset_o), .stat_halt_o(stat_halt_o),
    .flag_mode_o(flag_mode_o), .flag_rx_o(flag_rx_o),
    .mask_mode_o(mask_mode_o), .mask_rx_o(mask_rx_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // advance n clock edges, then park at the falling edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_ctl(input logic [2:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    step(1);
    ctl_wr = 1'b0;
    step(1);
  endtask

  task automatic tick_bt();
    bit_tick = 1'b1;
    step(1);
    bit_tick = 1'b0;
  endtask

  task automatic clear_mode_flag();
    clr_wr = 1'b1; clr_mode = 1'b1;
    step(1);
    clr_wr = 1'b0; clr_mode = 1'b0;
  endtask

  task automatic write_msk(input logic [1:0] v);
    msk_wr = 1'b1; msk_wdata = v;
    step(1);
    msk_wr = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1", "mode", mode_o, 0);
    chk("R1", "stat_reset", stat_reset_o, 1);
    chk("R1", "stat_halt", stat_halt_o, 0);
    chk("R1", "flag_mode", flag_mode_o, 1);
    chk("R1", "masks", {mask_rx_o, mask_mode_o}, 3);
    chk("R1", "flag_rx", flag_rx_o, 0);
    chk("R1", "irq", irq_o, 0);
  endtask

  task automatic t_leave_reset();
    write_ctl(3'b000);
    chk("R2", "mode normal", mode_o, 1);
    chk("R2", "stat_reset low", stat_reset_o, 0);
    clr_wr = 1'b1; clr_mode = 1'b0;
    step(1);
    clr_wr = 1'b0;
    chk("R8", "write 0 keeps flag", flag_mode_o, 1);
    clear_mode_flag();
    chk("R8", "write 1 clears flag", flag_mode_o, 0);
    write_msk(2'b10);
    chk("R10", "mode mask cleared", mask_mode_o, 0);
  endtask

  task automatic t_sleep_ignored();
    write_ctl(3'b100);
    step(2);
    chk("R4", "sleep ignored mode", mode_o, 1);
    chk("R4", "sleep ignored halt", stat_halt_o, 0);
    chk("R4", "sleep ignored flag", flag_mode_o, 0);
    write_ctl(3'b000);
  endtask

  task automatic t_halt();
    write_ctl(3'b010);
    chk("R3", "halt pending", mode_o, 2);
    chk("R3", "no halt status yet", stat_halt_o, 0);
    tick_bt();
    chk("R3", "halt mode", mode_o, 3);
    chk("R3", "halt status", stat_halt_o, 1);
    chk("R3", "flag set on halt", flag_mode_o, 1);
    chk("R10", "irq not yet", irq_o, 0);
    step(1);
    chk("R10", "irq raised", irq_o, 1);
    clear_mode_flag();
    chk("R10", "irq lags clear", irq_o, 1);
    step(1);
    chk("R10", "irq dropped", irq_o, 0);
  endtask

  task automatic t_sleep();
    write_ctl(3'b110);
    chk("R4", "sleep mode", mode_o, 4);
    chk("R4", "flag on sleep", flag_mode_o, 1);
    chk("R4", "halt status in sleep", stat_halt_o, 1);
    clear_mode_flag();
  endtask

  task automatic t_sleep_to_halt();
    write_ctl(3'b010);
    chk("R5", "sleep to halt", mode_o, 3);
    chk("R5", "no flag", flag_mode_o, 0);
  endtask

  task automatic t_exit();
    write_ctl(3'b000);
    chk("R6", "exit pending", mode_o, 5);
    chk("R6", "halt kept", stat_halt_o, 1);
    step(3);
    chk("R6", "waits for tick", mode_o, 5);
    tick_bt();
    chk("R6", "one tick halt kept", stat_halt_o, 1);
    tick_bt();
    chk("R6", "normal after two ticks", mode_o, 1);
    chk("R6", "halt cleared", stat_halt_o, 0);
    chk("R6", "no flag on exit", flag_mode_o, 0);
  endtask

  task automatic t_rehalt();
    write_ctl(3'b010);
    tick_bt();
    clear_mode_flag();
    write_ctl(3'b000);
    chk("R7", "exit pending", mode_o, 5);
    write_ctl(3'b010);
    chk("R7", "back to halt", mode_o, 3);
    chk("R7", "halt never dropped", stat_halt_o, 1);
    chk("R7", "no flag", flag_mode_o, 0);
    write_ctl(3'b000);
    tick_bt();
    tick_bt();
    chk("R7", "normal again", mode_o, 1);
  endtask

  task automatic t_set_wins();
    write_ctl(3'b010);
    bit_tick = 1'b1; clr_wr = 1'b1; clr_mode = 1'b1;
    step(1);
    bit_tick = 1'b0; clr_wr = 1'b0; clr_mode = 1'b0;
    chk("R8", "set beats clear", flag_mode_o, 1);
    clear_mode_flag();
    write_ctl(3'b000);
    tick_bt();
    tick_bt();
  endtask

  task automatic t_reset_from_sleep();
    write_ctl(3'b010);
    tick_bt();
    write_ctl(3'b110);
    clear_mode_flag();
    write_msk(2'b10);
    write_ctl(3'b111);
    chk("R11", "reset mode", mode_o, 0);
    chk("R11", "halt cleared", stat_halt_o, 0);
    chk("R11", "reset status", stat_reset_o, 1);
    chk("R2", "flag on reset", flag_mode_o, 1);
    chk("R2", "mask forced", mask_mode_o, 1);
    step(1);
    chk("R2", "no irq in reset", irq_o, 0);
    write_ctl(3'b000);
    chk("R2", "normal after reset", mode_o, 1);
    clear_mode_flag();
  endtask

  task automatic t_rx();
    write_msk(2'b00);
    mb_int_mask = 16'h0008;
    rx_pend = 16'h0008;
    rx_store = 1'b1; rx_store_mb = 4'd3;
    step(1);
    rx_store = 1'b0;
    chk("R9", "masked mailbox", flag_rx_o, 0);
    rx_pend = 16'h0028;
    rx_store = 1'b1; rx_store_mb = 4'd5;
    step(1);
    rx_store = 1'b0;
    chk("R9", "unmasked mailbox", flag_rx_o, 1);
    step(1);
    chk("R10", "irq from rx", irq_o, 1);
    rx_pend = 16'h0008;
    step(1);
    chk("R9", "held while pending", flag_rx_o, 1);
    rx_pend = 16'h0000;
    step(1);
    chk("R9", "cleared at zero", flag_rx_o, 0);
    rx_store = 1'b1; rx_store_mb = 4'd7;
    step(1);
    rx_store = 1'b0;
    chk("R9", "set beats clear", flag_rx_o, 1);
  endtask

  initial begin
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; clr_wr = 1'b0; clr_mode = 1'b0;
    msk_wr = 1'b0; msk_wdata = '0; bit_tick = 1'b0; rx_store = 1'b0;
    rx_store_mb = '0; mb_int_mask = '0; rx_pend = '0;
    step(3);
    rst_n = 1'b1;
    step(3);
    t_reset_state();
    t_leave_reset();
    t_sleep_ignored();
    t_halt();
    t_sleep();
    t_sleep_to_halt();
    t_exit();
    t_rehalt();
    t_set_wins();
    t_reset_from_sleep();
    t_rx();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule